// File: doc/BRIEF.md
# Indirect Register Access with Atomic Snapshot Buffer

This block gives a narrow command bus byte-wide access to a small register space through a single address pointer. A set-address command loads the pointer. Each indirect read or indirect write then works on the byte the pointer selects, and the pointer steps forward by one afterwards. Reads return data one cycle after the command. The space holds a four-byte staging buffer, a transfer base register, a transfer length register, two 32-bit event counters and a row of configuration bytes, which drive an output vector.

Two pointer values have a second meaning. Loading 0x00 copies up to four registers, starting at the base register, into the staging buffer. Loading 0x80 copies the buffer back into registers from the base upward. Either copy happens within a single clock, so a multi-byte counter is captured or replaced whole and never torn by a concurrent increment. The buffer is right-justified: the top byte is always used. A length outside 1..4 makes the command a plain pointer load.

Top module: `ind_snap_regs`

## Requirements
- R1: A command with op 0 (set address) loads `addr_o` with `cmd_data_i` on the next clock. This holds for the special values 0x00 and 0x80 as well.
- R2: A command with op 1 (indirect read) or op 2 (indirect write) increments `addr_o` by one afterwards, wrapping from 0xFF to 0x00. No valid command, or op 3, leaves `addr_o` unchanged.
- R3: One clock after an indirect read, `rd_valid_o` is high for one cycle and `rd_data_o` holds the byte at the pre-increment address. Addresses at or above NUM_REGS read as 0x00.
- R4: An indirect write stores `cmd_data_i` at the current address, and writes at or above NUM_REGS are dropped. The address map is as follows. Addresses 0..3 hold the staging buffer bytes b0..b3. Address 4 holds the transfer base and address 5 the transfer length. Addresses 6..9 hold the lost-character counter, least significant byte first, and 10..13 hold the framing-error counter in the same order. Address 14+j is configuration byte j, driven on `cfg_o[8j+7:8j]`.
- R5: Loading 0x00 with length n in 1..4 sets buffer byte b(4-n+k) to the register at address (base+k) mod 256, for k = 0..n-1. A source at or above NUM_REGS yields 0x00. All sources are taken from the state before that clock.
- R6: Loading 0x80 with length n in 1..4 writes buffer byte b(4-n+k) to address (base+k) mod 256, for k = 0..n-1. Destinations at or above NUM_REGS are skipped.
- R7: With length 0 or length 5 or more, loading 0x00 or 0x80 copies nothing, and no register other than the pointer changes.
- R8: A pulse on `lost_evt_i` or `ferr_evt_i` adds one to the matching 32-bit counter on that clock, wrapping modulo 2^32.
- R9: In a clock where any byte of a counter is written, by an indirect write or a write transfer, the written bytes take the new value, the other bytes keep their old value, and that clock's event for that counter is dropped.
- R10: A read transfer in the same clock as a counter event captures the counter value from before that event, and the counter still increments.
- R11: After reset, `addr_o`, `rd_valid_o`, `rd_data_o`, `cfg_o` and every register read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one command per clock |
| cmd_op_i | input | 2 | 0 set address, 1 indirect read, 2 indirect write, 3 no operation |
| cmd_data_i | input | 8 | Pointer value or write byte |
| lost_evt_i | input | 1 | Increment request for the lost-character counter |
| ferr_evt_i | input | 1 | Increment request for the framing-error counter |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| addr_o | output | 8 | Current indirect pointer |
| cfg_o | output | (NUM_REGS-14)*8 | Configuration bytes, byte j at bits 8j+7:8j |

## Verification
The bound checker watches the pointer every cycle: load, increment and hold. It also checks the one-cycle read-valid timing, the step-by-one and hold behaviour of the lost-character counter when no write touches it, and that the buffer and the first configuration byte stay put on an illegal-length transfer. It also checks the single-byte read-transfer copy. The wider behaviours need the bench's scenarios and its reference model. These are right-justified placement for every length, copies that wrap past address 0xFF, byte-wise counter overrides racing an event, and the snapshot taking the pre-event count.

// File: rtl/ind_snap_pkg.sv
package ind_snap_pkg;
  typedef enum logic [1:0] {
    OP_SET_ADDR = 2'd0,
    OP_IND_RD   = 2'd1,
    OP_IND_WR   = 2'd2,
    OP_NONE     = 2'd3
  } snap_op_e;

  localparam int BYTE_W     = 8;
  localparam int BUF_BYTES  = 4;
  localparam int XBASE_ADDR = 4;
  localparam int XLEN_ADDR  = 5;
  localparam int CTR_BYTES  = 4;
  localparam int NUM_CTRS   = 2;
  localparam int LOST_BASE  = 6;
  localparam int CTR_END    = LOST_BASE + NUM_CTRS * CTR_BYTES;
  localparam int CFG_BASE   = CTR_END;
endpackage

// File: rtl/ind_snap_ptr.sv
module ind_snap_ptr import ind_snap_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= ptr_o + BYTE_W'(1);
  end
endmodule

// File: rtl/ind_snap_route.sv
module ind_snap_route import ind_snap_pkg::*; #(
  parameter  int NUM_REGS = 24,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                              set_addr_i,
  input  logic                              wr_i,
  input  logic [BYTE_W-1:0]                 data_i,
  input  logic [BYTE_W-1:0]                 ptr_i,
  input  logic [NUM_REGS-1:0][BYTE_W-1:0]   view_i,
  output logic [NUM_REGS-1:0]               we_o,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]   wd_o
);
  function automatic logic in_rng(input logic [BYTE_W-1:0] a);
    return int'(a) < NUM_REGS;
  endfunction

  always_comb begin
    logic [BYTE_W-1:0] len;
    logic [BYTE_W-1:0] base;
    logic [BYTE_W-1:0] ra;
    logic              xfer;
    int                bi;
    we_o = '0;
    wd_o = '0;
    ra   = '0;
    bi   = 0;
    len  = view_i[XLEN_ADDR];
    base = view_i[XBASE_ADDR];
    xfer = set_addr_i && (data_i[6:0] == 7'd0) && (len != '0) && (len <= BYTE_W'(BUF_BYTES));
    if (wr_i && in_rng(ptr_i)) begin
      we_o[ptr_i[IDX_W-1:0]] = 1'b1;
      wd_o[ptr_i[IDX_W-1:0]] = data_i;
    end
    // all copies read the pre-clock view, so the block moves as one unit
    for (int k = 0; k < BUF_BYTES; k++) begin
      if (xfer && k < int'(len)) begin
        bi = BUF_BYTES - int'(len) + k;
        ra = base + BYTE_W'(k);
        if (data_i[7]) begin
          if (in_rng(ra)) begin
            we_o[ra[IDX_W-1:0]] = 1'b1;
            wd_o[ra[IDX_W-1:0]] = view_i[IDX_W'(bi)];
          end
        end else begin
          we_o[IDX_W'(bi)] = 1'b1;
          wd_o[IDX_W'(bi)] = in_rng(ra) ? view_i[ra[IDX_W-1:0]] : '0;
        end
      end
    end
  end
endmodule

// File: rtl/ind_snap_ctr.sv
module ind_snap_ctr import ind_snap_pkg::*; #(
  parameter int BYTES = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           evt_i,
  input  logic [BYTES-1:0]               byte_we_i,
  input  logic [BYTES-1:0][BYTE_W-1:0]   byte_wd_i,
  output logic [BYTES-1:0][BYTE_W-1:0]   cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (|byte_we_i) begin
      // a write owns the counter for this clock; the event is dropped
      for (int b = 0; b < BYTES; b++)
        if (byte_we_i[b]) cnt_o[b] <= byte_wd_i[b];
    end else if (evt_i) begin
      cnt_o <= cnt_o + (BYTES*BYTE_W)'(1);
    end
  end
endmodule

// File: rtl/ind_snap_regs.sv
module ind_snap_regs import ind_snap_pkg::*; #(
  parameter  int NUM_REGS = 24,
  localparam int NUM_CFG  = NUM_REGS - CFG_BASE,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [1:0]                cmd_op_i,
  input  logic [BYTE_W-1:0]         cmd_data_i,
  input  logic                      lost_evt_i,
  input  logic                      ferr_evt_i,
  output logic                      rd_valid_o,
  output logic [BYTE_W-1:0]         rd_data_o,
  output logic [BYTE_W-1:0]         addr_o,
  output logic [NUM_CFG*BYTE_W-1:0] cfg_o
);
  logic                            set_addr, rd_cmd, wr_cmd;
  logic [NUM_REGS-1:0][BYTE_W-1:0] view;
  logic [NUM_REGS-1:0][BYTE_W-1:0] wd;
  logic [NUM_REGS-1:0]             we;
  logic [NUM_CTRS-1:0]             ctr_evt;

  assign set_addr = cmd_valid_i && (cmd_op_i == OP_SET_ADDR);
  assign rd_cmd   = cmd_valid_i && (cmd_op_i == OP_IND_RD);
  assign wr_cmd   = cmd_valid_i && (cmd_op_i == OP_IND_WR);
  assign ctr_evt  = {ferr_evt_i, lost_evt_i};

  ind_snap_ptr u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (set_addr),
    .load_val_i (cmd_data_i),
    .inc_i      (rd_cmd || wr_cmd),
    .ptr_o      (addr_o)
  );

  ind_snap_route #(.NUM_REGS(NUM_REGS)) u_route (
    .set_addr_i (set_addr),
    .wr_i       (wr_cmd),
    .data_i     (cmd_data_i),
    .ptr_i      (addr_o),
    .view_i     (view),
    .we_o       (we),
    .wd_o       (wd)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i >= LOST_BASE && i < CTR_END) begin : g_ctr_slot
    end else begin : g_plain
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= '0;
        else if (we[i]) q <= wd[i];
      end
      assign view[i] = q;
    end
  end

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    localparam int B = LOST_BASE + c * CTR_BYTES;
    logic [CTR_BYTES-1:0][BYTE_W-1:0] cnt;
    ind_snap_ctr #(.BYTES(CTR_BYTES)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (ctr_evt[c]),
      .byte_we_i (we[B +: CTR_BYTES]),
      .byte_wd_i (wd[B +: CTR_BYTES]),
      .cnt_o     (cnt)
    );
    assign view[B +: CTR_BYTES] = cnt;
  end

  for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
    assign cfg_o[j*BYTE_W +: BYTE_W] = view[CFG_BASE + j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_cmd;
      if (rd_cmd)
        rd_data_o <= (int'(addr_o) < NUM_REGS) ? view[addr_o[IDX_W-1:0]] : '0;
    end
  end
endmodule

// File: rtl/ind_snap_regs_chk.sv
module ind_snap_regs_chk import ind_snap_pkg::*; #(
  parameter  int NUM_REGS = 24,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cmd_valid_i,
  input logic [1:0]                      cmd_op_i,
  input logic [BYTE_W-1:0]               cmd_data_i,
  input logic                            lost_evt_i,
  input logic                            rd_valid_o,
  input logic [BYTE_W-1:0]               addr_o,
  input logic [NUM_REGS-1:0][BYTE_W-1:0] view_i
);
  logic                     set_c, step_c, rd_c, special_c, bad_len, may_write;
  logic [BYTE_W-1:0]        len, base, src1;
  logic [CTR_BYTES*BYTE_W-1:0] lost;

  assign set_c     = cmd_valid_i && cmd_op_i == 2'd0;
  assign rd_c      = cmd_valid_i && cmd_op_i == 2'd1;
  assign step_c    = cmd_valid_i && (cmd_op_i == 2'd1 || cmd_op_i == 2'd2);
  assign special_c = set_c && cmd_data_i[6:0] == 7'd0;
  assign len       = view_i[XLEN_ADDR];
  assign base      = view_i[XBASE_ADDR];
  assign bad_len   = len == '0 || len > BYTE_W'(BUF_BYTES);
  assign src1      = (int'(base) < NUM_REGS) ? view_i[base[IDX_W-1:0]] : '0;
  assign lost      = view_i[LOST_BASE +: CTR_BYTES];
  assign may_write = cmd_valid_i && (cmd_op_i == 2'd2 || special_c);

  p_addr_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_c |=> addr_o == $past(cmd_data_i));
  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_c |=> addr_o == $past(addr_o) + 8'd1);
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_c || step_c) |=> $stable(addr_o));
  p_rd_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_c |=> rd_valid_o);
  p_rd_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_c |=> !rd_valid_o);
  p_rd_xfer_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (special_c && !cmd_data_i[7] && len == 8'd1) |=> view_i[BUF_BYTES-1] == $past(src1));
  p_bad_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (special_c && bad_len) |=>
      ($stable(view_i[BUF_BYTES-1:0]) && $stable(view_i[CFG_BASE])));
  p_ctr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_evt_i && !may_write) |=> lost == $past(lost) + 32'd1);
  p_ctr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_evt_i && !may_write) |=> $stable(lost));
endmodule

bind ind_snap_regs ind_snap_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_data_i  (cmd_data_i),
  .lost_evt_i  (lost_evt_i),
  .rd_valid_o  (rd_valid_o),
  .addr_o      (addr_o),
  .view_i      (view)
);

// File: tb/ind_snap_regs_bench.sv
module ind_snap_regs_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NR = 24;
  localparam int NC = NR - 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd3;
  logic [7:0]    cmd_data = '0;
  logic          lost_evt = 1'b0, ferr_evt = 1'b0;
  logic          rd_valid_o;
  logic [7:0]    rd_data_o, addr_o;
  logic [NC*8-1:0] cfg_o;

  logic [7:0] mdl [NR];
  logic [7:0] mptr;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int n_cmp = 0, n_err = 0;

  always #2.5 clk = ~clk;

  ind_snap_regs #(.NUM_REGS(NR)) u_ind_snap_regs (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .lost_evt_i(lost_evt), .ferr_evt_i(ferr_evt),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .addr_o(addr_o), .cfg_o(cfg_o)
  );

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read bytes as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_err++;
        $display("FAIL R3: got %0h expected no read", rd_data_o);
      end else begin
        cmp({24'd0, rd_data_o}, {24'd0, exp_q.pop_front()}, tag_q.pop_front());
      end
    end
  end

  // driver with reference model; pushes expected read data
  task automatic step(input logic v, input logic [1:0] op, input logic [7:0] d,
                      input logic le, input logic fe, input string tag = "R3");
    logic [7:0] nx [NR];
    bit wm [NR];
    int len, ra, bi, b;
    logic [31:0] cv;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_data = d; lost_evt = le; ferr_evt = fe;
    nx = mdl;
    for (int i = 0; i < NR; i++) wm[i] = 0;
    if (v) begin
      case (op)
        2'd0: begin
          len = int'(mdl[5]);
          if (d[6:0] == 7'd0 && len >= 1 && len <= 4) begin
            for (int k = 0; k < len; k++) begin
              bi = 4 - len + k;
              ra = int'(8'(mdl[4] + 8'(k)));
              if (d[7]) begin
                if (ra < NR) begin nx[ra] = mdl[bi]; wm[ra] = 1; end
              end else begin
                nx[bi] = (ra < NR) ? mdl[ra] : 8'h00; wm[bi] = 1;
              end
            end
          end
          mptr = d;
        end
        2'd1: begin
          exp_q.push_back(int'(mptr) < NR ? mdl[mptr] : 8'h00);
          tag_q.push_back(tag);
          mptr = mptr + 8'd1;
        end
        2'd2: begin
          if (int'(mptr) < NR) begin nx[mptr] = d; wm[mptr] = 1; end
          mptr = mptr + 8'd1;
        end
        default: ;
      endcase
    end
    for (int c = 0; c < 2; c++) begin
      b = 6 + 4 * c;
      if (!(wm[b] || wm[b+1] || wm[b+2] || wm[b+3]) && (c == 0 ? le : fe)) begin
        cv = {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]} + 32'd1;
        {nx[b+3], nx[b+2], nx[b+1], nx[b]} = cv;
      end
    end
    mdl = nx;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; lost_evt = 1'b0; ferr_evt = 1'b0;
  endtask

  task automatic set_a(input logic [7:0] a); step(1, 2'd0, a, 0, 0); endtask
  task automatic wr(input logic [7:0] d);    step(1, 2'd2, d, 0, 0); endtask
  task automatic rd(input string tag, input int n = 1);
    for (int i = 0; i < n; i++) step(1, 2'd1, 8'h00, 0, 0, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) mdl[i] = 8'h00;
    mptr = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    cmp({24'd0, addr_o}, 32'd0, "R11");
    cmp({31'd0, rd_valid_o}, 32'd0, "R11");
    cmp(cfg_o[31:0], 32'd0, "R11");
    set_a(8'hFF);
    rd("R3");             // 0xFF is out of range
    rd("R11", 14);        // addresses 0..13 after reset

    // R4 configuration bytes
    set_a(8'd14); wr(8'hA5); wr(8'h3C); wr(8'h7E);
    cmp(cfg_o[23:0], 32'h007E3CA5, "R4");
    set_a(8'd15); rd("R4", 2);

    // R1 / R2 pointer behaviour and wrap
    set_a(8'hFE);
    cmp({24'd0, addr_o}, 32'hFE, "R1");
    rd("R3", 2);
    cmp({24'd0, addr_o}, 32'h00, "R2");
    step(1, 2'd3, 8'h55, 0, 0);
    cmp({24'd0, addr_o}, 32'h00, "R2");
    step(0, 2'd2, 8'h55, 0, 0);
    cmp({24'd0, addr_o}, 32'h00, "R2");

    // R8 counters
    repeat (5) step(0, 2'd3, 8'h00, 1, 0);
    repeat (3) step(0, 2'd3, 8'h00, 1, 1);
    repeat (260) step(0, 2'd3, 8'h00, 0, 1);
    set_a(8'd6); rd("R8", 8);

    // R9 byte override races an event
    set_a(8'd6); step(1, 2'd2, 8'hF0, 1, 0);
    step(0, 2'd3, 8'h00, 1, 0);
    set_a(8'd6); rd("R9", 4);

    // R5 / R10 snapshot of the lost counter with a concurrent event
    set_a(8'd4); wr(8'd6); wr(8'd4);
    step(1, 2'd0, 8'h00, 1, 0);
    cmp({24'd0, addr_o}, 32'h00, "R1");
    set_a(8'hFF); rd("R10", 5);
    set_a(8'd6); rd("R10", 4);

    // R6 write transfer into configuration bytes
    set_a(8'hFF); wr(8'h99); wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
    set_a(8'd4); wr(8'd14); wr(8'd2);
    set_a(8'h80);
    cmp({24'd0, addr_o}, 32'h80, "R1");
    cmp(cfg_o[15:0], 32'h0403, "R6");
    rd("R3");
    // R6 / R9 whole-counter write while an event is pending
    set_a(8'd4); wr(8'd10); wr(8'd4);
    step(1, 2'd0, 8'h80, 0, 1);
    set_a(8'd10); rd("R6", 4);

    // R7 illegal lengths
    set_a(8'd5); wr(8'd5);
    set_a(8'h00); set_a(8'h80);
    set_a(8'd5); wr(8'd0);
    set_a(8'h00); set_a(8'h80);
    set_a(8'hFF); rd("R7", 5);
    set_a(8'd14); rd("R7", 2);

    // R5 copy wrapping past 0xFF
    set_a(8'd4); wr(8'hFE); wr(8'd3);
    set_a(8'h00);
    set_a(8'hFF); rd("R5", 5);
    // R5 single byte lands in top buffer byte
    set_a(8'd4); wr(8'd15); wr(8'd1);
    set_a(8'h00);
    set_a(8'd3); rd("R5");

    repeat (3) step(0, 2'd3, 8'h00, 0, 0);
    cmp(exp_q.size(), 32'd0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule